// File: doc/BRIEF.md
# Probe Trigger Condition Evaluator

This block watches a group of probe buses inside a chip and decides, on every sample clock, whether a programmed match condition holds. It feeds two single-bit results to a capture controller: a trigger-match strobe that tells the controller when to start recording, and a capture-qualify signal that tells it which samples are worth storing.

Each result comes from its own condition set. A condition set gives every probe an enable bit, a test mode (magnitude compare, fixed level, rising edge or falling edge), a 3-bit compare operator and a compare value. The per-probe outcomes are then merged under a set-wide choice of AND or OR, and probes whose enable is clear take no part in the merge.

Edge tests look at bit 0 of a probe and use a registered copy of the previous sample. Both results are registered, so each one reflects the probe values presented one sample clock earlier.

Top module: `trig_cond_eval`

## Requirements
- R1: Both outputs are registered. The result for the probe and configuration values present at a rising clock edge appears just after that edge. While reset (`rstN` low) is asserted, both outputs are 0.
- R2: The 2-bit per-probe mode field selects the test: 0 = magnitude compare, 1 = fixed level, 2 = rising edge, 3 = falling edge.
- R3: In rising-edge mode a probe holds when bit 0 of the probe was 0 at the previous sample and is 1 at the current sample.
- R4: In falling-edge mode a probe holds when bit 0 of the probe was 1 at the previous sample and is 0 at the current sample.
- R5: In level mode a probe holds when bit 0 of the probe equals bit 0 of its compare value. The other probe bits are ignored.
- R6: In compare mode the 3-bit operator selects an unsigned test of the probe value against the compare value: 0 equal, 1 not equal, 2 greater, 3 less, 4 greater-or-equal, 5 less-or-equal. Codes 6 and 7 never hold.
- R7: With the combine bit at 0 (AND), a result is 1 only when every enabled probe holds in the same sample.
- R8: With the combine bit at 1 (OR), a result is 1 when at least one enabled probe holds.
- R9: A probe whose enable bit is 0 affects neither combine mode. A set with no enabled probe gives 0.
- R10: No rising or falling edge is reported on the first sample after reset is released, whatever the probe value was during reset.
- R11: The trigger-match and capture-qualify results are computed from two independent configurations on the same probe inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| probeData | input | NUM_PROBES*PROBE_W | Probe buses; probe i occupies bits [i*PROBE_W +: PROBE_W] |
| trigEnable | input | NUM_PROBES | Trigger set: per-probe enable |
| trigMode | input | 2*NUM_PROBES | Trigger set: per-probe mode, 2 bits each |
| trigOp | input | 3*NUM_PROBES | Trigger set: per-probe operator, 3 bits each |
| trigValue | input | NUM_PROBES*PROBE_W | Trigger set: per-probe compare value |
| trigAnyMode | input | 1 | Trigger set combine: 0 AND, 1 OR |
| capEnable | input | NUM_PROBES | Capture set: per-probe enable |
| capMode | input | 2*NUM_PROBES | Capture set: per-probe mode |
| capOp | input | 3*NUM_PROBES | Capture set: per-probe operator |
| capValue | input | NUM_PROBES*PROBE_W | Capture set: per-probe compare value |
| capAnyMode | input | 1 | Capture set combine: 0 AND, 1 OR |
| trigMatch | output | 1 | Registered trigger-match result |
| capQualify | output | 1 | Registered capture-qualify result |

## Verification
Every result is due exactly one clock edge after the probe and configuration values it depends on. The bench therefore drives new values on the falling edge, waits for the next rising edge, and compares both outputs a moment later against a value it computes from those same inputs. Edge results also depend on the sample taken at the edge before that one. The bench keeps its own copy of the last sampled bit and advances it only on edges it has accounted for. It also checks the first edge after reset release separately, because no earlier sample exists there.

// File: rtl/tce_pkg.sv
package tce_pkg;

  typedef enum logic [1:0] {
    MODE_CMP   = 2'd0,
    MODE_LEVEL = 2'd1,
    MODE_RISE  = 2'd2,
    MODE_FALL  = 2'd3
  } probeMode_e;

  typedef enum logic [2:0] {
    OP_EQ   = 3'd0,
    OP_NE   = 3'd1,
    OP_GT   = 3'd2,
    OP_LT   = 3'd3,
    OP_GE   = 3'd4,
    OP_LE   = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } cmpOp_e;

  // strobes from the history control to each condition datapath
  typedef struct packed {
    logic edgeArm;   // a previous sample exists, edges may be reported
  } evalStrobe_t;

endpackage

// File: rtl/tce_ctrl.sv
module tce_ctrl
  import tce_pkg::*;
#(
  parameter int NUM_PROBES = 4,
  parameter int PROBE_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PROBES*PROBE_W-1:0] probeData,
  output evalStrobe_t                   strobes,
  output logic [NUM_PROBES-1:0]         prevBit
);

  logic [NUM_PROBES-1:0] curBit;
  logic                  histValid;

  for (genvar i = 0; i < NUM_PROBES; i++) begin : g_bit
    assign curBit[i] = probeData[i*PROBE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histValid <= 1'b0;
      prevBit   <= '0;
    end else begin
      histValid <= 1'b1;
      prevBit   <= curBit;
    end
  end

  assign strobes.edgeArm = histValid;

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    histValid |=> histValid); // R10

  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    histValid |=> (prevBit == $past(curBit))); // R3

endmodule

// File: rtl/tce_condset.sv
module tce_condset
  import tce_pkg::*;
#(
  parameter int NUM_PROBES = 4,
  parameter int PROBE_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PROBES*PROBE_W-1:0] probeData,
  input  logic [NUM_PROBES-1:0]         prevBit,
  input  evalStrobe_t                   strobes,
  input  logic [NUM_PROBES-1:0]         enable,
  input  logic [2*NUM_PROBES-1:0]       modeSel,
  input  logic [3*NUM_PROBES-1:0]       opSel,
  input  logic [NUM_PROBES*PROBE_W-1:0] cmpValue,
  input  logic                          combineOr,
  output logic                          match
);

  logic [NUM_PROBES-1:0] hit;
  logic [NUM_PROBES-1:0] isEdge;
  logic                  matchNext;

  for (genvar i = 0; i < NUM_PROBES; i++) begin : g_probe
    logic [PROBE_W-1:0] sampleVal;
    logic [PROBE_W-1:0] refVal;
    probeMode_e         modeVal;
    cmpOp_e             opVal;
    logic               cmpRes;
    logic               probeHit;

    assign sampleVal = probeData[i*PROBE_W +: PROBE_W];
    assign refVal    = cmpValue[i*PROBE_W +: PROBE_W];
    assign modeVal   = probeMode_e'(modeSel[2*i +: 2]);
    assign opVal     = cmpOp_e'(opSel[3*i +: 3]);

    always_comb begin
      case (opVal)
        OP_EQ:   cmpRes = (sampleVal == refVal);
        OP_NE:   cmpRes = (sampleVal != refVal);
        OP_GT:   cmpRes = (sampleVal >  refVal);
        OP_LT:   cmpRes = (sampleVal <  refVal);
        OP_GE:   cmpRes = (sampleVal >= refVal);
        OP_LE:   cmpRes = (sampleVal <= refVal);
        default: cmpRes = 1'b0;
      endcase
    end

    always_comb begin
      case (modeVal)
        MODE_CMP:   probeHit = cmpRes;
        MODE_LEVEL: probeHit = (sampleVal[0] == refVal[0]);
        MODE_RISE:  probeHit = strobes.edgeArm && !prevBit[i] && sampleVal[0];
        MODE_FALL:  probeHit = strobes.edgeArm && prevBit[i] && !sampleVal[0];
        default:    probeHit = 1'b0;
      endcase
    end

    assign hit[i]    = probeHit;
    assign isEdge[i] = (modeVal == MODE_RISE) || (modeVal == MODE_FALL);
  end

  always_comb begin
    if (enable == '0)
      matchNext = 1'b0;
    else if (combineOr)
      matchNext = |(hit & enable);
    else
      matchNext = ((hit & enable) == enable);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) match <= 1'b0;
    else       match <= matchNext;
  end

  AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (enable == '0) |=> !match); // R9

  AST_EDGE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.edgeArm |-> ((hit & isEdge) == '0)); // R10

  AST_AND_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!combineOr && ((hit & enable) != enable)) |=> !match); // R7

  AST_OR_ANY: assert property (@(posedge clk) disable iff (!rstN)
    (combineOr && ((hit & enable) != '0)) |=> match); // R8

endmodule

// File: rtl/trig_cond_eval.sv
module trig_cond_eval
  import tce_pkg::*;
#(
  parameter int NUM_PROBES = 4,
  parameter int PROBE_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PROBES*PROBE_W-1:0] probeData,
  input  logic [NUM_PROBES-1:0]         trigEnable,
  input  logic [2*NUM_PROBES-1:0]       trigMode,
  input  logic [3*NUM_PROBES-1:0]       trigOp,
  input  logic [NUM_PROBES*PROBE_W-1:0] trigValue,
  input  logic                          trigAnyMode,
  input  logic [NUM_PROBES-1:0]         capEnable,
  input  logic [2*NUM_PROBES-1:0]       capMode,
  input  logic [3*NUM_PROBES-1:0]       capOp,
  input  logic [NUM_PROBES*PROBE_W-1:0] capValue,
  input  logic                          capAnyMode,
  output logic                          trigMatch,
  output logic                          capQualify
);

  evalStrobe_t           strobes;
  logic [NUM_PROBES-1:0] prevBit;

  tce_ctrl #(.NUM_PROBES(NUM_PROBES), .PROBE_W(PROBE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .probeData(probeData),
    .strobes(strobes), .prevBit(prevBit)
  );

  tce_condset #(.NUM_PROBES(NUM_PROBES), .PROBE_W(PROBE_W)) u_trigSet (
    .clk(clk), .rstN(rstN), .probeData(probeData), .prevBit(prevBit),
    .strobes(strobes), .enable(trigEnable), .modeSel(trigMode),
    .opSel(trigOp), .cmpValue(trigValue), .combineOr(trigAnyMode),
    .match(trigMatch)
  );

  tce_condset #(.NUM_PROBES(NUM_PROBES), .PROBE_W(PROBE_W)) u_capSet (
    .clk(clk), .rstN(rstN), .probeData(probeData), .prevBit(prevBit),
    .strobes(strobes), .enable(capEnable), .modeSel(capMode),
    .opSel(capOp), .cmpValue(capValue), .combineOr(capAnyMode),
    .match(capQualify)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!trigMatch && !capQualify)); // R1

endmodule

// File: tb/trig_cond_eval_bench.sv
module trig_cond_eval_bench;
  localparam int N = 4;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N*W-1:0] probeData = '0;
  logic [N-1:0]   trigEnable = '0, capEnable = '0;
  logic [2*N-1:0] trigMode = '0, capMode = '0;
  logic [3*N-1:0] trigOp = '0, capOp = '0;
  logic [N*W-1:0] trigValue = '0, capValue = '0;
  logic           trigAnyMode = 1'b0, capAnyMode = 1'b0;
  logic           trigMatch, capQualify;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  trig_cond_eval #(.NUM_PROBES(N), .PROBE_W(W)) u_trig_cond_eval (.*);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic refCmp(input int op, input int a, input int b);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return a > b;
      3: return a < b;
      4: return a >= b;
      5: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic stepCheck(input string req, input logic expT, input logic expC);
    @(posedge clk); #1;
    check({req, " trig"}, trigMatch, expT);
    check({req, " cap"}, capQualify, expC);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset trig", trigMatch, 1'b0);
    check("R1 reset cap", capQualify, 1'b0);
    @(negedge clk) rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();

    // R6 / R2 / R1: compare mode sweep on probe 0; capture set idle (R9)
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int v = 0; v < 16; v++) begin
          @(negedge clk);
          trigEnable = 4'b0001; trigMode = '0; trigOp = 12'(op);
          trigValue = 16'(v); probeData = 16'(a) | 16'hA50;
          capEnable = '0;
          stepCheck("R6", refCmp(op, a, v), 1'b0);
        end

    // R5: level mode on each probe, upper bits varied
    for (int p = 0; p < N; p++)
      for (int d = 0; d < 16; d++)
        for (int x = 0; x < 2; x++) begin
          @(negedge clk);
          trigEnable = 4'(1 << p); trigMode = 8'(1 << (2*p));
          trigValue = 16'(x << (W*p)); probeData = 16'(d << (W*p));
          stepCheck("R5", (d % 2) == x, 1'b0);
        end

    // R7 / R8 / R9 / R11: trigger set AND, capture set OR, same probe tests
    for (int en = 0; en < 16; en++)
      for (int hm = 0; hm < 16; hm++) begin
        logic [N*W-1:0] pd;
        logic expAnd, expOr;
        pd = '0;
        for (int p = 0; p < N; p++)
          pd[p*W +: W] = ((hm >> p) & 1) != 0 ? 4'd5 : 4'd3;
        @(negedge clk);
        probeData = pd;
        trigEnable = 4'(en); trigMode = '0; trigOp = '0;
        trigValue = 16'h5555; trigAnyMode = 1'b0;
        capEnable = 4'(en); capMode = '0; capOp = '0;
        capValue = 16'h5555; capAnyMode = 1'b1;
        expAnd = (en != 0) && ((hm & en) == en);
        expOr  = (hm & en) != 0;
        stepCheck("R7 R8 R9 R11", expAnd, expOr);
      end

    // R10 / R3 / R4: edges on probe 0, trigger rise, capture fall
    trigAnyMode = 1'b0; capAnyMode = 1'b0;
    trigEnable = 4'b0001; trigMode = 8'd2;
    capEnable = 4'b0001; capMode = 8'd3;
    probeData = 16'h0001;
    doReset();
    stepCheck("R10 first sample", 1'b0, 1'b0);
    begin
      logic prev;
      prev = 1'b1;
      for (int k = 0; k < 48; k++) begin
        logic b;
        b = ((k * 5 + 1) % 7) > 3;
        @(negedge clk);
        probeData = {15'(k), b};
        stepCheck("R3 R4", !prev && b, prev && !b);
        prev = b;
      end
    end

    // R10 with prior value 0 during reset, high at release
    probeData = 16'h0000;
    doReset();
    probeData = 16'h0001;
    stepCheck("R10 rise at release", 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule